// File: doc/BRIEF.md
# Time-Slot Interchange Output Channel Engine

This block is a small time-slot interchange switch for several parallel receive and transmit streams, each divided into a fixed number of byte channels per frame. A channel counter, restarted by a frame sync pulse, walks through the channels one clock cycle at a time. Every cycle the byte of the current channel on every receive stream is written into a data store. For each transmit stream, the block looks up a connection entry for the current channel. It then sends a byte switched from the store, a constant set by the processor, or nothing (the slot is tri-stated).

Each connection entry has a high word and a low word. The high word carries a mode field. The low word carries either the source slot address or the constant byte. The data store has two banks that swap at every frame start. The constant-delay mode always reads the previous frame's bank. The variable-delay mode may read a byte received earlier in the current frame. Two global controls sit above the per-channel modes. A bypass control copies each receive stream straight to the matching transmit stream. An output gate tri-states every channel when both the drive-enable pin and the standby control are low.

Top module: `tsi_switch`

## Requirements
- R1: A cycle with `fsync` high is channel 0 of a new frame. Otherwise the channel advances by one each cycle and wraps from NCHAN-1 to 0, which also starts a new frame. The first cycle after reset is channel 0.
- R2: A connection write stores `cm_wdata` at entry `cm_addr` when `cm_we` is high: the high word when `cm_hi` is 1 and the low word otherwise. The entry for stream s, channel c is at address s*NCHAN+c. Only bits 2:0 of the high word (the mode field) take effect. The write is seen from the next cycle on.
- R3: Mode 3'b100 (processor constant) drives bits 7:0 of the low word with output-enable high, in every frame, until the entry changes.
- R4: Mode 3'b001 (constant delay) drives the byte that arrived in the previous frame at the source slot. The source slot is bits SLOT_W-1:0 of the low word, read as stream*NCHAN+channel.
- R5: Mode 3'b000 (variable delay) drives the current frame's byte when the source channel is lower than the current channel. Otherwise it drives the previous frame's byte at that slot.
- R6: Mode 3'b111 and the unused codes 3'b010, 3'b011, 3'b101 and 3'b110 drive output-enable low for that slot. Whenever output-enable is low, the data lines are 0.
- R7: While `ode` and `standby` are both low, every transmit slot has output-enable low and data 0, whatever the mode and the bypass setting.
- R8: While `bypass` is 1 and the outputs are not gated off, each transmit stream carries the byte its own receive stream had one cycle earlier, with output-enable high, whatever the connection entries hold.
- R9: During reset all transmit data and output-enables are 0. Each transmit output is registered: the value for the channel presented in one cycle appears after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one channel per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Marks channel 0 of a frame |
| rx_data | input | NSTREAM*W (32) | Receive bytes of the current channel, stream s at bits s*W+:W |
| bypass | input | 1 | Route each receive stream straight to its transmit stream |
| ode | input | 1 | External output drive enable |
| standby | input | 1 | Control bit that also enables the outputs |
| cm_we | input | 1 | Connection entry write strobe |
| cm_hi | input | 1 | Selects the high word (1) or low word (0) |
| cm_addr | input | SLOT_W (7) | Connection entry address, stream*NCHAN+channel |
| cm_wdata | input | 16 | Connection word to store |
| tx_data | output | NSTREAM*W (32) | Transmit bytes, stream s at bits s*W+:W |
| tx_oe | output | NSTREAM (4) | Per-stream output-enable for the slot now on tx_data |

## Verification
Random connection maps draw all eight mode codes. Each receive slot carries a fresh random byte, so a wrong source slot, a wrong bank or a wrong frame shows up as a wrong byte. Directed entries point variable-delay channels at sources earlier than, later than and equal to their own position. These are the cases where variable and constant delay give different bytes. One stream holds constants coded by channel, and it is run through a regular sync, an early sync and a missing sync, which exposes any counter or wrap error. Bypass and the output gate are combined with random maps and with changes to entries during traffic, to show that they override the per-channel modes and that entry writes take effect one cycle later.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  // Per-slot action decoded from the 3-bit mode field of the high word
  typedef enum logic [1:0] {
    ACT_OFF   = 2'd0,
    ACT_PROC  = 2'd1,
    ACT_FIXED = 2'd2,
    ACT_LIVE  = 2'd3
  } slot_act_e;

  localparam logic [2:0] MODE_LIVE  = 3'b000;
  localparam logic [2:0] MODE_FIXED = 3'b001;
  localparam logic [2:0] MODE_PROC  = 3'b100;
  localparam logic [2:0] MODE_HIZ   = 3'b111;

  // Unlisted codes fall through to the off action
  function automatic slot_act_e decode_mode(input logic [2:0] m);
    case (m)
      MODE_PROC:  return ACT_PROC;
      MODE_FIXED: return ACT_FIXED;
      MODE_LIVE:  return ACT_LIVE;
      default:    return ACT_OFF;
    endcase
  endfunction

  // A source channel already passed in this frame is held in the live bank
  function automatic logic earlier_in_frame(input int unsigned src_ch,
                                            input int unsigned cur_ch);
    return src_ch < cur_ch;
  endfunction

  // Flat slot index of a stream/channel pair
  function automatic int unsigned slot_index(input int unsigned stream,
                                             input int unsigned chan,
                                             input int unsigned nchan);
    return stream * nchan + chan;
  endfunction

endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer #(
  parameter  int NCHAN = 32,
  localparam int CH_W  = $clog2(NCHAN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fsync,
  output logic [CH_W-1:0] cur_ch,
  output logic            wr_bank
);

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCHAN - 1);

  logic [CH_W-1:0] ch_q;
  logic            bank_q;
  logic            frame_start;

  always_comb begin
    if (fsync)                cur_ch = '0;
    else if (ch_q == LAST_CH) cur_ch = '0;
    else                      cur_ch = ch_q + 1'b1;
    frame_start = (cur_ch == '0);
    wr_bank     = frame_start ? ~bank_q : bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q   <= LAST_CH;
      bank_q <= 1'b0;
    end else begin
      ch_q   <= cur_ch;
      bank_q <= wr_bank;
    end
  end

  // R1: a sync cycle is channel 0
  a_r1_sync_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (ch_q == '0));
  // R1: wrap after the last channel
  a_r1_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && ch_q == LAST_CH) |=> (ch_q == '0));
  // R1: plain step inside a frame
  a_r1_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && ch_q != LAST_CH) |=> (ch_q == $past(ch_q) + 1'b1));
  // R4: the banks swap at every frame start
  a_r4_bank_swap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (bank_q != $past(bank_q)));

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter  int NSTREAM = 4,
  parameter  int NCHAN   = 32,
  parameter  int W       = 8,
  localparam int CH_W    = $clog2(NCHAN),
  localparam int NSLOT   = NSTREAM * NCHAN,
  localparam int SLOT_W  = $clog2(NSLOT)
) (
  input  logic                  clk,
  input  logic                  wr_bank,
  input  logic [CH_W-1:0]       wr_ch,
  input  logic [NSTREAM*W-1:0]  wr_data,
  input  logic [NSTREAM-1:0]    rd_bank,
  input  logic [NSTREAM*SLOT_W-1:0] rd_slot,
  output logic [NSTREAM*W-1:0]  rd_data
);

  logic [W-1:0] mem [2][NSLOT];

  // All streams of the current channel land in the write bank together
  always_ff @(posedge clk) begin
    for (int s = 0; s < NSTREAM; s++) begin
      mem[wr_bank][SLOT_W'(s * NCHAN) + SLOT_W'(wr_ch)] <= wr_data[s*W +: W];
    end
  end

  // One read port per transmit stream
  for (genvar p = 0; p < NSTREAM; p++) begin : g_rd
    assign rd_data[p*W +: W] = mem[rd_bank[p]][rd_slot[p*SLOT_W +: SLOT_W]];
  end

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter  int NSLOT  = 128,
  parameter  int NRD    = 4,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic                  sel_hi,
  input  logic [SLOT_W-1:0]     waddr,
  input  logic [15:0]           wdata,
  input  logic [NRD*SLOT_W-1:0] raddr,
  output logic [NRD*3-1:0]      rmode,
  output logic [NRD*16-1:0]     rlow
);

  logic [2:0]  mode_m [NSLOT];
  logic [15:0] low_m  [NSLOT];

  always_ff @(posedge clk) begin
    if (we) begin
      if (sel_hi) mode_m[waddr] <= wdata[2:0];
      else        low_m[waddr]  <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rmode[p*3 +: 3]  = mode_m[raddr[p*SLOT_W +: SLOT_W]];
    assign rlow[p*16 +: 16] = low_m[raddr[p*SLOT_W +: SLOT_W]];
  end

endmodule

// File: rtl/tsi_out_lane.sv
module tsi_out_lane
  import tsi_pkg::*;
#(
  parameter  int NSTREAM = 4,
  parameter  int NCHAN   = 32,
  parameter  int W       = 8,
  localparam int CH_W    = $clog2(NCHAN),
  localparam int SLOT_W  = $clog2(NSTREAM * NCHAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_en,
  input  logic              bypass,
  input  logic [2:0]        mode,
  input  logic [15:0]       low,
  input  logic [CH_W-1:0]   cur_ch,
  input  logic              wr_bank,
  input  logic [W-1:0]      rx_byte,
  input  logic [W-1:0]      rd_byte,
  output logic              rd_bank,
  output logic [SLOT_W-1:0] rd_slot,
  output logic [W-1:0]      tx_q,
  output logic              oe_q
);

  slot_act_e       act;
  logic [CH_W-1:0] src_ch;
  logic            from_live;
  logic [W-1:0]    nxt_d;
  logic            nxt_oe;
  logic            unused_low;

  assign unused_low = ^low;

  always_comb begin
    act       = decode_mode(mode);
    rd_slot   = low[SLOT_W-1:0];
    src_ch    = rd_slot[CH_W-1:0];
    from_live = (act == ACT_LIVE) && earlier_in_frame(32'(src_ch), 32'(cur_ch));
    rd_bank   = from_live ? wr_bank : ~wr_bank;
  end

  always_comb begin
    nxt_d  = '0;
    nxt_oe = 1'b0;
    if (gen_en) begin
      if (bypass) begin
        nxt_d  = rx_byte;
        nxt_oe = 1'b1;
      end else begin
        case (act)
          ACT_PROC: begin
            nxt_d  = low[W-1:0];
            nxt_oe = 1'b1;
          end
          ACT_FIXED, ACT_LIVE: begin
            nxt_d  = rd_byte;
            nxt_oe = 1'b1;
          end
          default: begin
            nxt_d  = '0;
            nxt_oe = 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      oe_q <= 1'b0;
    end else begin
      tx_q <= nxt_d;
      oe_q <= nxt_oe;
    end
  end

  // R3: processor constant one cycle later
  a_r3_proc_const: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && !bypass && mode == MODE_PROC) |=> (oe_q && tx_q == $past(low[W-1:0])));
  // R6: high-impedance code silences the slot
  a_r6_hiz_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && mode == MODE_HIZ) |=> (!oe_q && tx_q == '0));
  // R6: disabled slot carries zero data
  a_r6_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> (tx_q == '0));
  // R8: bypass copies the receive byte
  a_r8_bypass_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && bypass) |=> (oe_q && tx_q == $past(rx_byte)));

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter  int NSTREAM = 4,
  parameter  int NCHAN   = 32,
  parameter  int W       = 8,
  localparam int CH_W    = $clog2(NCHAN),
  localparam int NSLOT   = NSTREAM * NCHAN,
  localparam int SLOT_W  = $clog2(NSLOT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fsync,
  input  logic [NSTREAM*W-1:0] rx_data,
  input  logic                 bypass,
  input  logic                 ode,
  input  logic                 standby,
  input  logic                 cm_we,
  input  logic                 cm_hi,
  input  logic [SLOT_W-1:0]    cm_addr,
  input  logic [15:0]          cm_wdata,
  output logic [NSTREAM*W-1:0] tx_data,
  output logic [NSTREAM-1:0]   tx_oe
);

  logic [CH_W-1:0]           cur_ch;
  logic                      wr_bank;
  logic                      gen_en;
  logic [NSTREAM*SLOT_W-1:0] cm_raddr;
  logic [NSTREAM*3-1:0]      cm_mode;
  logic [NSTREAM*16-1:0]     cm_low;
  logic [NSTREAM-1:0]        rd_bank;
  logic [NSTREAM*SLOT_W-1:0] rd_slot;
  logic [NSTREAM*W-1:0]      rd_data;

  assign gen_en = ode | standby;

  tsi_frame_timer #(.NCHAN(NCHAN)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .fsync   (fsync),
    .cur_ch  (cur_ch),
    .wr_bank (wr_bank)
  );

  tsi_data_mem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN), .W(W)) u_dmem (
    .clk     (clk),
    .wr_bank (wr_bank),
    .wr_ch   (cur_ch),
    .wr_data (rx_data),
    .rd_bank (rd_bank),
    .rd_slot (rd_slot),
    .rd_data (rd_data)
  );

  tsi_conn_mem #(.NSLOT(NSLOT), .NRD(NSTREAM)) u_cmem (
    .clk    (clk),
    .we     (cm_we),
    .sel_hi (cm_hi),
    .waddr  (cm_addr),
    .wdata  (cm_wdata),
    .raddr  (cm_raddr),
    .rmode  (cm_mode),
    .rlow   (cm_low)
  );

  for (genvar s = 0; s < NSTREAM; s++) begin : g_lane
    assign cm_raddr[s*SLOT_W +: SLOT_W] =
      SLOT_W'(tsi_pkg::slot_index(s, 32'(cur_ch), NCHAN));

    tsi_out_lane #(.NSTREAM(NSTREAM), .NCHAN(NCHAN), .W(W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .gen_en  (gen_en),
      .bypass  (bypass),
      .mode    (cm_mode[s*3 +: 3]),
      .low     (cm_low[s*16 +: 16]),
      .cur_ch  (cur_ch),
      .wr_bank (wr_bank),
      .rx_byte (rx_data[s*W +: W]),
      .rd_byte (rd_data[s*W +: W]),
      .rd_bank (rd_bank[s]),
      .rd_slot (rd_slot[s*SLOT_W +: SLOT_W]),
      .tx_q    (tx_data[s*W +: W]),
      .oe_q    (tx_oe[s])
    );
  end

  // R7: global gate silences every stream, bypass included
  a_r7_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !(ode || standby) |=> (tx_oe == '0 && tx_data == '0));

endmodule

// File: tb/test_tsi_switch.sv
module test_tsi_switch;

  localparam int NSTREAM = 4;
  localparam int NCHAN   = 32;
  localparam int W       = 8;
  localparam int NSLOT   = NSTREAM * NCHAN;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 fsync = 1'b0;
  logic [NSTREAM*W-1:0] rx_data = '0;
  logic                 bypass = 1'b0;
  logic                 ode = 1'b0;
  logic                 standby = 1'b0;
  logic                 cm_we = 1'b0;
  logic                 cm_hi = 1'b0;
  logic [6:0]           cm_addr = '0;
  logic [15:0]          cm_wdata = '0;
  logic [NSTREAM*W-1:0] tx_data;
  logic [NSTREAM-1:0]   tx_oe;

  tsi_switch #(.NSTREAM(NSTREAM), .NCHAN(NCHAN), .W(W)) i_tsi_switch (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .rx_data(rx_data),
    .bypass(bypass), .ode(ode), .standby(standby),
    .cm_we(cm_we), .cm_hi(cm_hi), .cm_addr(cm_addr), .cm_wdata(cm_wdata),
    .tx_data(tx_data), .tx_oe(tx_oe)
  );

  always #5 clk = ~clk;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  // reference model state
  bit [2:0]  m_mode [NSLOT];
  bit [15:0] m_low  [NSLOT];
  bit [7:0]  cur_d  [NSTREAM][NCHAN];
  bit        cur_v  [NSTREAM][NCHAN];
  bit [7:0]  prev_d [NSTREAM][NCHAN];
  bit        prev_v [NSTREAM][NCHAN];
  int        mch = NCHAN - 1;

  // pending drive values
  bit        d_byp = 0, d_ode = 0, d_sb = 0;
  bit        p_we = 0, p_hi = 0;
  bit [6:0]  p_addr = 0;
  bit [15:0] p_data = 0;
  string     ovr [NSTREAM];

  // expectations for the next sample
  bit        have_exp = 0;
  bit        e_chk [NSTREAM];
  bit        e_oe  [NSTREAM];
  bit [7:0]  e_d   [NSTREAM];
  string     e_req [NSTREAM];

  function automatic bit [2:0] pick_mode();
    int r = int'($urandom % 8);
    if (r < 2) return 3'b000;
    if (r < 4) return 3'b001;
    if (r < 6) return 3'b100;
    if (r == 6) return 3'b111;
    case ($urandom % 4)
      0: return 3'b010;
      1: return 3'b011;
      2: return 3'b101;
      default: return 3'b110;
    endcase
  endfunction

  // Called at a falling edge: check, drive, predict, advance one cycle
  task automatic tick(input bit fs);
    bit [31:0] rxv;
    int c;
    if (have_exp) begin
      for (int s = 0; s < NSTREAM; s++) begin
        if (e_chk[s]) begin
          nvec++;
          if (tx_oe[s] !== e_oe[s] || tx_data[s*W +: W] !== e_d[s]) begin
            nbad++;
            $display("FAIL %s stream %0d ch %0d: actual oe=%0b data=%02h, expected oe=%0b data=%02h",
                     e_req[s], s, mch, tx_oe[s], tx_data[s*W +: W], e_oe[s], e_d[s]);
          end
        end
      end
    end
    rxv      = $urandom;
    rx_data  = rxv;
    fsync    = fs;
    bypass   = d_byp;
    ode      = d_ode;
    standby  = d_sb;
    cm_we    = p_we;
    cm_hi    = p_hi;
    cm_addr  = p_addr;
    cm_wdata = p_data;
    c = fs ? 0 : ((mch == NCHAN - 1) ? 0 : mch + 1);
    if (c == 0) begin
      for (int s = 0; s < NSTREAM; s++)
        for (int k = 0; k < NCHAN; k++) begin
          prev_d[s][k] = cur_d[s][k];
          prev_v[s][k] = cur_v[s][k];
          cur_v[s][k]  = 0;
        end
    end
    for (int s = 0; s < NSTREAM; s++) begin
      int slot = s * NCHAN + c;
      e_chk[s] = 1; e_oe[s] = 0; e_d[s] = 0; e_req[s] = "R7";
      if (d_ode || d_sb) begin
        if (d_byp) begin
          e_oe[s] = 1; e_d[s] = rxv[s*W +: W]; e_req[s] = "R8";
        end else begin
          int src = int'(m_low[slot][6:0]);
          int ss = src / NCHAN;
          int sc = src % NCHAN;
          case (m_mode[slot])
            3'b100: begin
              e_oe[s] = 1; e_d[s] = m_low[slot][7:0];
              e_req[s] = (ovr[s] != "") ? ovr[s] : "R3";
            end
            3'b001: begin
              e_oe[s] = 1; e_req[s] = "R4";
              if (prev_v[ss][sc]) e_d[s] = prev_d[ss][sc]; else e_chk[s] = 0;
            end
            3'b000: begin
              e_oe[s] = 1; e_req[s] = "R5";
              if (sc < c) begin
                if (cur_v[ss][sc]) e_d[s] = cur_d[ss][sc]; else e_chk[s] = 0;
              end else begin
                if (prev_v[ss][sc]) e_d[s] = prev_d[ss][sc]; else e_chk[s] = 0;
              end
            end
            default: begin
              e_oe[s] = 0; e_d[s] = 0; e_req[s] = "R6";
            end
          endcase
        end
      end
    end
    for (int s = 0; s < NSTREAM; s++) begin
      cur_d[s][c] = rxv[s*W +: W];
      cur_v[s][c] = 1;
    end
    if (p_we) begin
      if (p_hi) m_mode[p_addr] = p_data[2:0];
      else      m_low[p_addr]  = p_data;
    end
    p_we = 0;
    mch = c;
    have_exp = 1;
    @(negedge clk);
  endtask

  task automatic cm_write(input int addr, input bit hi, input bit [15:0] d);
    p_we = 1; p_hi = hi; p_addr = 7'(addr); p_data = d;
    tick(mch == NCHAN - 1);
  endtask

  task automatic run(input int n, input bit sync, input bit live_wr);
    for (int i = 0; i < n; i++) begin
      if (live_wr && ($urandom % 4) == 0) begin
        p_we = 1; p_hi = $urandom % 2; p_addr = 7'($urandom);
        p_data = p_hi ? {13'($urandom), pick_mode()} : 16'($urandom);
      end
      tick(sync && (mch == NCHAN - 1));
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nbad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7781));
    for (int s = 0; s < NSTREAM; s++) ovr[s] = "";
    repeat (3) @(negedge clk);
    // R9: reset state
    nvec++;
    if (tx_oe !== '0 || tx_data !== '0) begin
      nbad++;
      $display("FAIL R9 reset: actual oe=%h data=%h, expected oe=0 data=0", tx_oe, tx_data);
    end
    rst_n = 1'b1;

    // fill the connection map while the gate is closed (R7)
    for (int a = 0; a < NSLOT; a++) begin
      cm_write(a, 1, {13'($urandom), pick_mode()});
      cm_write(a, 0, 16'($urandom));
    end

    // open the gate, traffic with live map changes
    d_ode = 1;
    run(6 * NCHAN, 1, 1);

    // R4/R5 corner sources on stream 1: earlier, later, same position
    cm_write(1*NCHAN + 4, 1, 16'h0000); cm_write(1*NCHAN + 4, 0, 16'(1*NCHAN + 2));
    cm_write(1*NCHAN + 5, 1, 16'h0000); cm_write(1*NCHAN + 5, 0, 16'(1*NCHAN + 20));
    cm_write(1*NCHAN + 6, 1, 16'h0001); cm_write(1*NCHAN + 6, 0, 16'(1*NCHAN + 6));
    cm_write(1*NCHAN + 7, 1, 16'h0000); cm_write(1*NCHAN + 7, 0, 16'(1*NCHAN + 7));
    run(3 * NCHAN, 1, 0);

    // R2: only the mode bits of the high word count
    for (int k = 0; k < NCHAN; k++) begin
      cm_write(2*NCHAN + k, 1, {13'h1FFF & 13'($urandom | 32'h1000), 3'b100});
      cm_write(2*NCHAN + k, 0, {8'($urandom), 8'(k * 7 + 3)});
    end
    ovr[2] = "R2";
    run(2 * NCHAN, 1, 0);
    ovr[2] = "";

    // R1: channel-coded constants through early and missing syncs
    for (int k = 0; k < NCHAN; k++) begin
      cm_write(3*NCHAN + k, 1, 16'h0004);
      cm_write(3*NCHAN + k, 0, {8'($urandom), 8'(8'h40 + k)});
    end
    ovr[3] = "R1";
    run(NCHAN, 1, 0);
    run(10, 0, 0);
    tick(1);
    run(3 * NCHAN + 5, 0, 0);
    run(2 * NCHAN, 1, 0);
    ovr[3] = "";

    // R8: bypass, then bypass under a closed gate (R7)
    d_byp = 1;
    run(2 * NCHAN, 1, 1);
    d_ode = 0;
    run(12, 1, 0);
    d_ode = 1;
    d_byp = 0;
    run(NCHAN, 1, 1);

    // standby bit alone opens the gate; both low closes it
    d_ode = 0; d_sb = 1;
    run(2 * NCHAN, 1, 1);
    d_sb = 0;
    run(12, 1, 1);

    // mixed tail with dropped syncs
    d_ode = 1;
    for (int i = 0; i < 4 * NCHAN; i++) begin
      if (($urandom % 4) == 0) begin
        p_we = 1; p_hi = $urandom % 2; p_addr = 7'($urandom);
        p_data = p_hi ? {13'($urandom), pick_mode()} : 16'($urandom);
      end
      tick((mch == NCHAN - 1) && (($urandom % 3) != 0));
    end
    tick(0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule